// File: doc/BRIEF.md
# Byte Register Array with Guarded Window

This block is a 32-entry array of 8-bit registers with one processor-facing access port. Each accepted command moves four bytes at once. A write stores the four bytes of a 32-bit word at four consecutive addresses. A read returns the bytes at four consecutive addresses in a registered word, together with a one-cycle valid flag. Addresses wrap modulo the array size, so an access that starts near the top continues at address 0.

A fixed window of six bytes (addresses 10 to 15) cannot be changed by processor writes. Any lane of a write that lands in the window is dropped, and the other lanes of the same word are still stored. The window can be loaded only through a narrow internal port that takes a window index, a byte and an enable. A control bit (bit 7 of byte 3) requests a wipe of the window. Whenever that bit is seen set at a clock edge, the window is zeroed and the bit clears itself at that same edge.

Top module: `byte_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears all 32 bytes, `out_valid` and `out_data` at the clock edge where it is sampled high.
- R2: With `in_valid`=1 and `cmd`=1, byte lane i (`data_in[8*i+7:8*i]`, i = 0..3) is stored at address (`addr`+i) mod 32.
- R3: A write lane whose target address lies in 10..15 is discarded, and the other lanes of that command are still stored.
- R4: With `in_valid`=1 and `cmd`=0, at the next edge `out_valid` becomes 1 and `out_data[8*i+7:8*i]` holds the byte at (`addr`+i) mod 32 as it stood before that edge.
- R5: In any cycle without a read command, `out_valid` is 0 after the edge and `out_data` keeps its previous value.
- R6: At an edge where bit 7 of byte 3 is 1, bytes 10..15 become zero and that bit becomes 0, while bits 6..0 of byte 3 are kept.
- R7: With `side_we`=1 and `side_idx`=k for k in 0..5, byte 10+k takes `side_data` at the edge; index values 6 and 7 change nothing.
- R8: When a window wipe and a side-port write fall on the same edge, the targeted byte ends as zero.
- R9: When a processor write to byte 3 falls on the same edge as the self-clear of its bit 7, byte 3 takes the written byte, and the window is still zeroed.
- R10: An access whose four addresses run past 31 continues at address 0 for both reads and writes.
- R11: With `in_valid`=0, no byte changes through the processor port, whatever `cmd`, `addr` and `data_in` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A processor command is present |
| cmd | input | 1 | 1 = write four bytes, 0 = read four bytes |
| addr | input | 5 | First byte address of the access |
| data_in | input | 32 | Write data, lane i on bits 8*i+7..8*i |
| side_we | input | 1 | Internal window write enable |
| side_idx | input | 3 | Window byte index (0 selects byte 10) |
| side_data | input | 8 | Internal window write byte |
| out_valid | output | 1 | Registered read-valid flag |
| out_data | output | 32 | Registered read word |

## Verification
The two functions that can fall on one edge are the self-clearing wipe of the window and a write that touches a wiped byte or the control byte itself. The bench sets bit 7 of byte 3 with a processor write. In the very next cycle it issues either a side-port write into the window or a processor write of a new byte 3 value whose bit 7 is clear. It then reads the window and byte 3 back through the normal read command. A zero window together with the written byte 3 value, rather than the old value with bit 7 masked, shows that the ordering is correct.

// File: rtl/regf_pkg.sv
package regf_pkg;

  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  // Wrap a base address plus offset into an array of n entries.
  function automatic int wrap_index(input int base, input int ofs, input int n);
    int s;
    s = base + ofs;
    while (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/regf_lane_decode.sv
module regf_lane_decode
  import regf_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int LANES     = 4,
  parameter int WIN_LO    = 10,
  parameter int WIN_HI    = 15,
  parameter int CTRL_ADDR = 3,
  localparam int ADDR_W   = $clog2(NUM_BYTES)
) (
  input  logic                          wr_req,
  input  logic [ADDR_W-1:0]             addr,
  output logic [LANES-1:0][ADDR_W-1:0]  lane_addr,
  output logic [LANES-1:0]              lane_we,
  output logic                          ctrl_hit
);

  localparam int SUM_W = ADDR_W + 1;

  logic [LANES-1:0] lane_ctrl;

  // One address generator and window filter per byte lane.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SUM_W-1:0] raw_sum;
    logic [SUM_W-1:0] wrapped;
    logic             in_window;

    assign raw_sum   = {1'b0, addr} + SUM_W'(l);
    assign wrapped   = (raw_sum >= SUM_W'(NUM_BYTES)) ? raw_sum - SUM_W'(NUM_BYTES)
                                                      : raw_sum;
    assign in_window = (wrapped >= SUM_W'(WIN_LO)) && (wrapped <= SUM_W'(WIN_HI));

    assign lane_addr[l] = wrapped[ADDR_W-1:0];
    assign lane_we[l]   = wr_req && !in_window;
    assign lane_ctrl[l] = lane_we[l] && (wrapped == SUM_W'(CTRL_ADDR));
  end

  assign ctrl_hit = |lane_ctrl;

endmodule

// File: rtl/regf_byte_array.sv
module regf_byte_array
  import regf_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int LANES     = 4,
  parameter int WIN_LO    = 10,
  parameter int WIN_HI    = 15,
  parameter int CTRL_ADDR = 3,
  parameter int CTRL_BIT  = 7,
  localparam int ADDR_W   = $clog2(NUM_BYTES),
  localparam int WIN_N    = WIN_HI - WIN_LO + 1,
  localparam int SIDE_W   = (WIN_N > 1) ? $clog2(WIN_N) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANES-1:0][ADDR_W-1:0]  lane_addr,
  input  logic [LANES-1:0]              lane_we,
  input  logic [LANES-1:0][BYTE_W-1:0]  lane_wdata,
  input  logic                          side_we,
  input  logic [SIDE_W-1:0]             side_idx,
  input  logic [BYTE_W-1:0]             side_data,
  output logic [LANES-1:0][BYTE_W-1:0]  lane_rdata,
  output logic                          ctrl_bit,
  output logic                          win_zero
);

  byte_t mem     [NUM_BYTES];
  byte_t mem_nxt [NUM_BYTES];
  logic  wipe;
  logic  side_ok;

  assign wipe    = mem[CTRL_ADDR][CTRL_BIT];
  assign side_ok = side_we && (int'(side_idx) < WIN_N);

  // Update order sets the priorities: self-clear of the control bit,
  // side-port load, window wipe (beats side port), processor lanes
  // (beat the self-clear on the control byte).
  always_comb begin
    mem_nxt = mem;
    if (wipe) begin
      mem_nxt[CTRL_ADDR][CTRL_BIT] = 1'b0;
    end
    if (side_ok) begin
      mem_nxt[ADDR_W'(WIN_LO + int'(side_idx))] = side_data;
    end
    if (wipe) begin
      for (int k = WIN_LO; k <= WIN_HI; k++) begin
        mem_nxt[ADDR_W'(k)] = '0;
      end
    end
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) begin
        mem_nxt[lane_addr[l]] = lane_wdata[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BYTES; b++) begin
        mem[b] <= '0;
      end
    end else begin
      mem <= mem_nxt;
    end
  end

  // Read muxes, one per lane.
  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign lane_rdata[l] = mem[lane_addr[l]];
  end

  // Window-empty flag for the bound checker.
  always_comb begin
    win_zero = 1'b1;
    for (int k = WIN_LO; k <= WIN_HI; k++) begin
      if (mem[ADDR_W'(k)] != '0) win_zero = 1'b0;
    end
  end

  assign ctrl_bit = wipe;

endmodule

// File: rtl/regf_read_port.sv
module regf_read_port
  import regf_pkg::*;
#(
  parameter int LANES    = 4,
  localparam int DATA_W  = LANES * BYTE_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_req,
  input  logic [LANES-1:0][BYTE_W-1:0]  rd_bytes,
  output logic                          out_valid,
  output logic [DATA_W-1:0]             out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= rd_req;
      if (rd_req) begin
        out_data <= rd_bytes;
      end
    end
  end

endmodule

// File: rtl/byte_regfile.sv
module byte_regfile
  import regf_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int LANES     = 4,
  parameter int WIN_LO    = 10,
  parameter int WIN_HI    = 15,
  parameter int CTRL_ADDR = 3,
  parameter int CTRL_BIT  = 7,
  localparam int ADDR_W   = $clog2(NUM_BYTES),
  localparam int DATA_W   = LANES * BYTE_W,
  localparam int WIN_N    = WIN_HI - WIN_LO + 1,
  localparam int SIDE_W   = (WIN_N > 1) ? $clog2(WIN_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              side_we,
  input  logic [SIDE_W-1:0] side_idx,
  input  logic [7:0]        side_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic                          wr_req;
  logic                          rd_req;
  logic [LANES-1:0][ADDR_W-1:0]  lane_addr;
  logic [LANES-1:0]              lane_we;
  logic [LANES-1:0][BYTE_W-1:0]  lane_wdata;
  logic [LANES-1:0][BYTE_W-1:0]  lane_rdata;
  logic                          ctrl_hit;
  logic                          ctrl_bit;
  logic                          win_zero;

  assign wr_req     = in_valid && cmd;
  assign rd_req     = in_valid && !cmd;
  assign lane_wdata = data_in;

  regf_lane_decode #(
    .NUM_BYTES (NUM_BYTES),
    .LANES     (LANES),
    .WIN_LO    (WIN_LO),
    .WIN_HI    (WIN_HI),
    .CTRL_ADDR (CTRL_ADDR)
  ) i_decode (
    .wr_req    (wr_req),
    .addr      (addr),
    .lane_addr (lane_addr),
    .lane_we   (lane_we),
    .ctrl_hit  (ctrl_hit)
  );

  regf_byte_array #(
    .NUM_BYTES (NUM_BYTES),
    .LANES     (LANES),
    .WIN_LO    (WIN_LO),
    .WIN_HI    (WIN_HI),
    .CTRL_ADDR (CTRL_ADDR),
    .CTRL_BIT  (CTRL_BIT)
  ) i_array (
    .clk        (clk),
    .rst        (rst),
    .lane_addr  (lane_addr),
    .lane_we    (lane_we),
    .lane_wdata (lane_wdata),
    .side_we    (side_we),
    .side_idx   (side_idx),
    .side_data  (side_data),
    .lane_rdata (lane_rdata),
    .ctrl_bit   (ctrl_bit),
    .win_zero   (win_zero)
  );

  regf_read_port #(
    .LANES (LANES)
  ) i_read (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rd_bytes  (lane_rdata),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/regf_chk.sv
module regf_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              cmd,
  input logic              side_we,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              ctrl_bit,
  input logic              ctrl_hit,
  input logic              win_zero
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  p_rdvalid_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cmd) |=> out_valid);

  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && !cmd) |=> !out_valid);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && !cmd) |=> $stable(out_data));

  p_selfclr_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bit && !ctrl_hit) |=> !ctrl_bit);

  p_wipe_r6: assert property (@(posedge clk) disable iff (rst)
    ctrl_bit |=> win_zero);

  p_wipe_beats_side_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bit && side_we) |=> win_zero);

endmodule

bind byte_regfile regf_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cmd       (cmd),
  .side_we   (side_we),
  .out_valid (out_valid),
  .out_data  (out_data),
  .ctrl_bit  (ctrl_bit),
  .ctrl_hit  (ctrl_hit),
  .win_zero  (win_zero)
);

// File: tb/test_byte_regfile.sv
module test_byte_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        cmd = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] data_in = '0;
  logic        side_we = 1'b0;
  logic [2:0]  side_idx = '0;
  logic [7:0]  side_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int failures = 0;

  // Reference state built from the requirements.
  logic [7:0]  m [32];
  logic        mv;
  logic [31:0] md;

  // Table entries: {valid, cmd, addr[4:0], data[31:0]}
  localparam logic [38:0] VEC [12] = '{
    {1'b1, 1'b1, 5'd0,  32'h44332211},  // R2 plain write
    {1'b1, 1'b0, 5'd0,  32'h0},         // R4 read back
    {1'b1, 1'b1, 5'd8,  32'hDDCCBBAA},  // R3 lanes 10,11 dropped
    {1'b1, 1'b0, 5'd8,  32'h0},         // R3 read 8..11
    {1'b1, 1'b1, 5'd30, 32'h04030201},  // R10 write wraps
    {1'b1, 1'b0, 5'd30, 32'h0},         // R10 read wraps
    {1'b1, 1'b1, 5'd13, 32'h87654321},  // R3 only byte 16 lands
    {1'b1, 1'b0, 5'd13, 32'h0},         // R3 read 13..16
    {1'b0, 1'b1, 5'd0,  32'hFFFFFFFF},  // R11 no valid, no write
    {1'b1, 1'b0, 5'd0,  32'h0},         // R11 bytes 0..3 unchanged
    {1'b0, 1'b0, 5'd4,  32'h0},         // R5 idle keeps data
    {1'b1, 1'b0, 5'd28, 32'h0}          // R10 read 28..31
  };

  byte_regfile i_byte_regfile (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .cmd       (cmd),
    .addr      (addr),
    .data_in   (data_in),
    .side_we   (side_we),
    .side_idx  (side_idx),
    .side_data (side_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 32; b++) m[b] = 8'h00;
    mv = 1'b0;
    md = '0;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    side_we = 1'b0;
    model_reset();
    @(posedge clk);
    #1;
    check({tag, " out_valid"}, {31'b0, out_valid}, 32'h0);
    check({tag, " out_data"}, out_data, 32'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic v, input logic c, input logic [4:0] a,
                      input logic [31:0] d, input logic swe, input logic [2:0] si,
                      input logic [7:0] sd, input string tag);
    logic [7:0] n [32];
    logic       wipe;
    int         ad;
    @(negedge clk);
    in_valid = v; cmd = c; addr = a; data_in = d;
    side_we = swe; side_idx = si; side_data = sd;
    n = m;
    wipe = m[3][7];
    if (wipe) n[3][7] = 1'b0;
    if (swe && si < 3'd6) n[10 + int'(si)] = sd;
    if (wipe) for (int k = 10; k <= 15; k++) n[k] = 8'h00;
    if (v && c) begin
      for (int i = 0; i < 4; i++) begin
        ad = (int'(a) + i) % 32;
        if (ad < 10 || ad > 15) n[ad] = d[8*i +: 8];
      end
    end
    if (v && !c) begin
      mv = 1'b1;
      for (int i = 0; i < 4; i++) md[8*i +: 8] = m[(int'(a) + i) % 32];
    end else begin
      mv = 1'b0;
    end
    m = n;
    @(posedge clk);
    #1;
    check({tag, " out_valid"}, {31'b0, out_valid}, {31'b0, mv});
    check({tag, " out_data"}, out_data, md);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, a, d, 1'b0, 3'd0, 8'h00, tag);
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'h0, 1'b0, 3'd0, 8'h00, tag);
  endtask

  task automatic side(input logic [2:0] si, input logic [7:0] sd, input string tag);
    step(1'b0, 1'b0, 5'd0, 32'h0, 1'b1, si, sd, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    model_reset();
    repeat (2) @(posedge clk);
    do_reset("R1 initial");

    // Table walk
    for (int t = 0; t < 12; t++) begin
      step(VEC[t][38], VEC[t][37], VEC[t][36:32], VEC[t][31:0],
           1'b0, 3'd0, 8'h00, $sformatf("R2/R3/R4/R5/R10/R11 vec%0d", t));
    end

    // R7: side port loads the window, out-of-range index ignored
    for (int k = 0; k < 6; k++) side(3'(k), 8'h50 + 8'(k), "R7 load");
    side(3'd6, 8'hE6, "R7 idx6");
    side(3'd7, 8'hE7, "R7 idx7");
    rd(5'd10, "R7 read 10..13");
    rd(5'd14, "R7 read 14..17");

    // R6: set control bit, wipe happens on the following edge
    wr(5'd0, 32'h95000000, "R6 set bit");
    step(1'b0, 1'b0, 5'd0, 32'h0, 1'b0, 3'd0, 8'h00, "R6 wipe edge");
    rd(5'd0, "R6 ctrl byte kept low bits");
    rd(5'd10, "R6 window zero a");
    rd(5'd12, "R6 window zero b");

    // R8: wipe and side write on the same edge
    side(3'd2, 8'h77, "R8 preload");
    wr(5'd0, 32'h80000000, "R8 set bit");
    side(3'd2, 8'hEE, "R8 side on wipe edge");
    rd(5'd12, "R8 byte 12 zero");

    // R9: processor write of byte 3 on the self-clear edge
    side(3'd0, 8'h3C, "R9 preload");
    wr(5'd0, 32'h95000000, "R9 set bit");
    wr(5'd3, 32'h0000002A, "R9 write on clear edge");
    rd(5'd0, "R9 byte 3 holds written value");
    rd(5'd10, "R9 window still wiped");

    // R1: reset from a dirty state
    wr(5'd20, 32'hCAFEF00D, "R1 dirty");
    do_reset("R1 rerun");
    for (int w = 0; w < 8; w++) rd(5'(4 * w), "R1 array zero");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule